// File: doc/BRIEF.md
# D-Channel Access Priority Arbiter

This block decides when a terminal on a shared, point-to-multipoint signalling bus may begin sending on the D channel. All terminals watch the echo (E) bit that the network side reflects back in every frame. A run of ones in that echo means the channel is idle. The arbiter counts each consecutive echoed one and starts over on any echoed zero. A terminal holding a pending packet is allowed onto the channel once the count reaches the active threshold.

The threshold depends on two settings. A user-selected class picks the range: the high class uses 8 or 9 ones, and the low class uses 10 or 11. Inside that range an internal level picks one value. The internal level is high after reset, which gives the smaller value of the pair. After each packet that completes without a collision, the level drops to low. It returns to high only after the low-level run of ones has been seen. This lets other terminals take turns.

While the grant is active, every echoed bit is compared with the D bit this terminal sent in the same position. A mismatch means another terminal is also sending. When that happens the arbiter drops the grant, pulses an abort so the rest of the packet is thrown away, and raises a sticky collision interrupt. It keeps the acknowledge bit set until the next frame pulse and restarts counting from zero.

The controller has four states:

- COUNT: counting; no grant.
- SEND: granted.
- ABORT: one cycle after a collision.
- HOLD: waiting for a frame pulse after a collision.

Its transitions are:

- COUNT to SEND (take): a packet is pending and the count is at or above the threshold.
- SEND to ABORT (collide): a strobed echo differs from the sent D bit.
- SEND to COUNT (finish): packet done and no collision.
- ABORT to COUNT (resync): frame pulse seen during ABORT.
- ABORT to HOLD (wait): no frame pulse during ABORT.
- HOLD to COUNT (resync): frame pulse seen during HOLD.

Top module: `dch_access_arbiter`

## Requirements
- R1: After reset, tx_grant, pkt_abort, dch_ack and coll_irq are 0, the echo count is zero and the internal level is high.
- R2: Each cycle with echo_vld=1 and echo_bit=1 adds one to the count, and echo_vld=1 with echo_bit=0 sets it to zero. Cycles with echo_vld=0 leave it unchanged. The count is also zeroed on the take transition and throughout SEND.
- R3: The threshold is 8 when class_low=0 with level high, 9 when class_low=0 with level low, 10 when class_low=1 with level high, and 11 when class_low=1 with level low.
- R4: In COUNT, if tx_pending=1 and the count is at or above the threshold at a clock edge, then tx_grant and dch_ack are 1 from the next cycle on.
- R5: The count saturates. Once it is at or above the threshold it stops rising, and a later pending request is granted at the next edge without any further ones.
- R6: In SEND, a strobe with echo_bit different from tx_dbit makes tx_grant 0 in the next cycle. In that same cycle pkt_abort is 1 for exactly one cycle and coll_irq becomes 1.
- R7: coll_irq stays 1 until a cycle with irq_clear=1. A collision in the same cycle as irq_clear leaves coll_irq set.
- R8: After a collision, dch_ack stays 1 until a frame_pulse cycle and is 0 from the cycle after it. Counting restarts from zero and proceeds during that wait.
- R9: In SEND, pkt_done=1 without a collision makes tx_grant and dch_ack 0 from the next cycle and sets the internal level low.
- R10: With the level low, the level returns to high at the edge after the count has reached the low-level threshold of the selected class.
- R11: If a collision and pkt_done occur in the same cycle, the collision wins: the abort follows and the level is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| echo_vld | input | 1 | Strobe: one echo bit is present this cycle |
| echo_bit | input | 1 | Value of the echoed E bit |
| tx_dbit | input | 1 | D bit this terminal sent in the echoed position |
| frame_pulse | input | 1 | Frame boundary pulse |
| tx_pending | input | 1 | A packet is waiting to be sent |
| pkt_done | input | 1 | Current packet finished sending |
| class_low | input | 1 | User class: 0 high (8/9), 1 low (10/11) |
| irq_clear | input | 1 | Clears the collision interrupt |
| tx_grant | output | 1 | D channel granted to this terminal |
| coll_irq | output | 1 | Sticky collision interrupt |
| pkt_abort | output | 1 | One-cycle pulse: discard the rest of the packet |
| dch_ack | output | 1 | D-channel acknowledge bit |

## Verification
Every output is a registered state decode. An input applied before clock edge k therefore shows its effect at the outputs in the cycle right after edge k. That covers a grant, an abort, an interrupt set or clear, and an acknowledge drop. A level change shows one edge later, through the threshold used by the next take. The bench drives inputs on the falling edge. It advances a behavioural model at each rising edge and compares all four outputs at the following falling edge, so each result is sampled exactly one edge after its cause. The long runs of ones for each class and level, together with the colliding and finishing packets, check every threshold value against the cycle in which the grant actually appears.

// File: rtl/dch_arb_pkg.sv
package dch_arb_pkg;

    typedef enum logic [1:0] {
        ST_COUNT = 2'd0,
        ST_SEND  = 2'd1,
        ST_ABORT = 2'd2,
        ST_HOLD  = 2'd3
    } arb_state_e;

endpackage

// File: rtl/dch_echo_counter.sv
module dch_echo_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             strobe,
    input  logic             bit_in,
    input  logic [CNT_W-1:0] thr,
    output logic [CNT_W-1:0] cnt_q
);

    logic at_limit;

    // saturate at or above the active threshold
    assign at_limit = (cnt_q >= thr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (strobe) begin
            if (!bit_in) begin
                cnt_q <= '0;
            end else if (!at_limit) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/dch_level_select.sv
module dch_level_select #(
    parameter int HI_BASE = 8,
    parameter int LO_BASE = 10,
    parameter int CNT_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             class_low,
    input  logic             drop,
    input  logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] thr,
    output logic             lvl_low_q
);

    logic [CNT_W-1:0] base;
    logic             restore;

    always_comb begin
        base = class_low ? CNT_W'(LO_BASE) : CNT_W'(HI_BASE);
        thr  = base + {{(CNT_W-1){1'b0}}, lvl_low_q};
    end

    // low level returns to high once the low-level run was seen
    assign restore = lvl_low_q && (cnt_q >= thr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_low_q <= 1'b0;
        end else if (drop) begin
            lvl_low_q <= 1'b1;
        end else if (restore) begin
            lvl_low_q <= 1'b0;
        end
    end

endmodule

// File: rtl/dch_access_fsm.sv
module dch_access_fsm
    import dch_arb_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             echo_vld,
    input  logic             echo_bit,
    input  logic             tx_dbit,
    input  logic             frame_pulse,
    input  logic             tx_pending,
    input  logic             pkt_done,
    input  logic             irq_clear,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [CNT_W-1:0] thr,
    output logic             cnt_clr,
    output logic             done_ok,
    output logic             tx_grant,
    output logic             coll_irq,
    output logic             pkt_abort,
    output logic             dch_ack
);

    arb_state_e state_q, state_d;
    logic       take;
    logic       coll;
    logic       irq_q;

    assign take    = (state_q == ST_COUNT) && tx_pending && (cnt_q >= thr);
    assign coll    = (state_q == ST_SEND) && echo_vld && (echo_bit ^ tx_dbit);
    assign done_ok = (state_q == ST_SEND) && pkt_done && !coll;
    assign cnt_clr = (state_q == ST_SEND) || take;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COUNT: if (take) state_d = ST_SEND;
            ST_SEND: begin
                if (coll)          state_d = ST_ABORT;
                else if (pkt_done) state_d = ST_COUNT;
            end
            ST_ABORT: state_d = frame_pulse ? ST_COUNT : ST_HOLD;
            ST_HOLD:  if (frame_pulse) state_d = ST_COUNT;
            default:  state_d = ST_COUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_COUNT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         irq_q <= 1'b0;
        else if (coll)      irq_q <= 1'b1;
        else if (irq_clear) irq_q <= 1'b0;
    end

    always_comb begin
        tx_grant  = 1'b0;
        pkt_abort = 1'b0;
        dch_ack   = 1'b0;
        unique case (state_q)
            ST_COUNT: ;
            ST_SEND: begin
                tx_grant = 1'b1;
                dch_ack  = 1'b1;
            end
            ST_ABORT: begin
                pkt_abort = 1'b1;
                dch_ack   = 1'b1;
            end
            ST_HOLD: dch_ack = 1'b1;
            default: ;
        endcase
        coll_irq = irq_q;
    end

endmodule

// File: rtl/dch_access_arbiter.sv
module dch_access_arbiter #(
    parameter int HI_BASE = 8,
    parameter int LO_BASE = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic echo_vld,
    input  logic echo_bit,
    input  logic tx_dbit,
    input  logic frame_pulse,
    input  logic tx_pending,
    input  logic pkt_done,
    input  logic class_low,
    input  logic irq_clear,
    output logic tx_grant,
    output logic coll_irq,
    output logic pkt_abort,
    output logic dch_ack
);

    localparam int MAX_THR = ((LO_BASE > HI_BASE) ? LO_BASE : HI_BASE) + 1;
    localparam int CNT_W   = $clog2(MAX_THR + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] thr;
    logic             lvl_low_q;
    logic             cnt_clr;
    logic             done_ok;

    dch_echo_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cnt_clr),
        .strobe (echo_vld),
        .bit_in (echo_bit),
        .thr    (thr),
        .cnt_q  (cnt_q)
    );

    dch_level_select #(
        .HI_BASE (HI_BASE),
        .LO_BASE (LO_BASE),
        .CNT_W   (CNT_W)
    ) lvl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .class_low (class_low),
        .drop      (done_ok),
        .cnt_q     (cnt_q),
        .thr       (thr),
        .lvl_low_q (lvl_low_q)
    );

    dch_access_fsm #(.CNT_W(CNT_W)) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .echo_vld    (echo_vld),
        .echo_bit    (echo_bit),
        .tx_dbit     (tx_dbit),
        .frame_pulse (frame_pulse),
        .tx_pending  (tx_pending),
        .pkt_done    (pkt_done),
        .irq_clear   (irq_clear),
        .cnt_q       (cnt_q),
        .thr         (thr),
        .cnt_clr     (cnt_clr),
        .done_ok     (done_ok),
        .tx_grant    (tx_grant),
        .coll_irq    (coll_irq),
        .pkt_abort   (pkt_abort),
        .dch_ack     (dch_ack)
    );

endmodule

// File: rtl/dch_access_arbiter_chk.sv
module dch_access_arbiter_chk #(
    parameter int MAX_CNT = 11,
    parameter int CNT_W   = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             echo_vld,
    input logic             echo_bit,
    input logic             tx_dbit,
    input logic             frame_pulse,
    input logic             pkt_done,
    input logic             irq_clear,
    input logic             tx_grant,
    input logic             coll_irq,
    input logic             pkt_abort,
    input logic             dch_ack,
    input logic [CNT_W-1:0] cnt_q
);

    // R2
    zero_echo_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (echo_vld && !echo_bit) |=> (cnt_q == '0));

    // R5
    cnt_saturates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(MAX_CNT));

    // R4
    grant_has_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_grant |-> dch_ack);

    // R6
    collision_aborts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_grant && echo_vld && (echo_bit != tx_dbit)) |=> (!tx_grant && pkt_abort && coll_irq));

    // R6
    abort_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_abort |=> !pkt_abort);

    // R7
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (coll_irq && !irq_clear) |=> coll_irq);

    // R8
    ack_held_to_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dch_ack && !tx_grant && !frame_pulse) |=> dch_ack);

    // R9
    done_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_grant && pkt_done && !(echo_vld && (echo_bit != tx_dbit))) |=> (!tx_grant && !dch_ack));

endmodule

bind dch_access_arbiter dch_access_arbiter_chk #(
    .MAX_CNT (MAX_THR),
    .CNT_W   (CNT_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .echo_vld    (echo_vld),
    .echo_bit    (echo_bit),
    .tx_dbit     (tx_dbit),
    .frame_pulse (frame_pulse),
    .pkt_done    (pkt_done),
    .irq_clear   (irq_clear),
    .tx_grant    (tx_grant),
    .coll_irq    (coll_irq),
    .pkt_abort   (pkt_abort),
    .dch_ack     (dch_ack),
    .cnt_q       (cnt_q)
);

// File: tb/dch_access_arbiter_tb_top.sv
module dch_access_arbiter_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic echo_vld = 1'b0, echo_bit = 1'b0, tx_dbit = 1'b0, frame_pulse = 1'b0;
    logic tx_pending = 1'b0, pkt_done = 1'b0, class_low = 1'b0, irq_clear = 1'b0;
    logic tx_grant, coll_irq, pkt_abort, dch_ack;

    int    vectors = 0;
    int    miscompares = 0;
    string cur_req = "R1";

    // behavioural reference: 0 count, 1 send, 2 abort, 3 hold
    int m_st = 0, m_cnt = 0, m_low = 0, m_irq = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dch_access_arbiter dut_i (
        .clk(clk), .rst_n(rst_n), .echo_vld(echo_vld), .echo_bit(echo_bit),
        .tx_dbit(tx_dbit), .frame_pulse(frame_pulse), .tx_pending(tx_pending),
        .pkt_done(pkt_done), .class_low(class_low), .irq_clear(irq_clear),
        .tx_grant(tx_grant), .coll_irq(coll_irq), .pkt_abort(pkt_abort),
        .dch_ack(dch_ack)
    );

    task automatic model_step();
        int thr, n_st, n_cnt, n_low;
        bit take, coll;
        thr  = (class_low ? 10 : 8) + m_low;
        take = (m_st == 0) && tx_pending && (m_cnt >= thr);
        coll = (m_st == 1) && echo_vld && (echo_bit != tx_dbit);
        n_st = m_st;
        if (m_st == 0 && take) n_st = 1;
        else if (m_st == 1 && coll) n_st = 2;
        else if (m_st == 1 && pkt_done) n_st = 0;
        else if (m_st == 2) n_st = frame_pulse ? 0 : 3;
        else if (m_st == 3 && frame_pulse) n_st = 0;
        n_cnt = m_cnt;
        if (m_st == 1 || take) n_cnt = 0;
        else if (echo_vld) n_cnt = echo_bit ? ((m_cnt >= thr) ? m_cnt : m_cnt + 1) : 0;
        n_low = m_low;
        if (m_st == 1 && pkt_done && !coll) n_low = 1;
        else if (m_low == 1 && m_cnt >= thr) n_low = 0;
        if (coll) m_irq = 1;
        else if (irq_clear) m_irq = 0;
        m_st = n_st; m_cnt = n_cnt; m_low = n_low;
    endtask

    task automatic compare();
        logic eg, ei, ea, ek;
        eg = (m_st == 1);
        ea = (m_st == 2);
        ek = (m_st != 0);
        ei = (m_irq != 0);
        vectors++;
        if (tx_grant !== eg || coll_irq !== ei || pkt_abort !== ea || dch_ack !== ek) begin
            miscompares++;
            $display("FAIL %s t=%0t grant/irq/abort/ack actual=%b%b%b%b expected=%b%b%b%b",
                     cur_req, $time, tx_grant, coll_irq, pkt_abort, dch_ack, eg, ei, ea, ek);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic echo(input logic b, input int n);
        for (int i = 0; i < n; i++) begin
            echo_vld = 1'b1; echo_bit = b; tx_dbit = b;
            tick();
        end
        echo_vld = 1'b0;
    endtask

    task automatic finish_pkt();
        pkt_done = 1'b1; tick(); pkt_done = 1'b0; tick();
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        miscompares++;
        $display("FAIL R1 watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1";
        compare();
        tick();

        // R2: partial run broken by a zero, then restart
        cur_req = "R2";
        echo(1'b1, 5); echo(1'b0, 1); echo(1'b1, 3);
        tx_pending = 1'b1; tick();
        echo(1'b1, 4); tick();
        // R3: eighth one reaches the high-class high-level threshold
        cur_req = "R3";
        echo(1'b1, 1);
        // R4: grant and ack follow
        cur_req = "R4";
        tick(); tick();
        // R9: matching echoes, then a clean finish lowers the level
        cur_req = "R9";
        echo(1'b1, 1); echo(1'b0, 1);
        tx_pending = 1'b0;
        finish_pkt();

        // R3: low level needs nine
        cur_req = "R3";
        tx_pending = 1'b1;
        echo(1'b1, 8); tick();
        cur_req = "R10";
        echo(1'b1, 1); tick();
        finish_pkt();
        tx_pending = 1'b0;
        echo(1'b1, 9);
        // R5: saturation, then immediate grant
        cur_req = "R5";
        echo(1'b1, 4);
        tx_pending = 1'b1; tick(); tick();
        tx_pending = 1'b0;
        finish_pkt();
        // R10: restore then eight are enough again
        cur_req = "R10";
        echo(1'b1, 9); echo(1'b0, 1);
        tx_pending = 1'b1;
        echo(1'b1, 8); tick();
        tx_pending = 1'b0;
        finish_pkt();

        // R3: low class thresholds 11 and 10
        cur_req = "R3";
        class_low = 1'b1;
        echo(1'b1, 11); echo(1'b0, 1);
        tx_pending = 1'b1;
        echo(1'b1, 9); tick();
        echo(1'b1, 1); tick();
        finish_pkt();
        echo(1'b1, 10); tick();
        echo(1'b1, 1); tick();
        tx_pending = 1'b0;
        finish_pkt();
        class_low = 1'b0;

        // R6: collision while sending
        cur_req = "R6";
        tx_pending = 1'b1;
        echo(1'b1, 12); tick();
        tx_pending = 1'b0;
        echo_vld = 1'b1; echo_bit = 1'b0; tx_dbit = 1'b1; tick();
        echo_vld = 1'b0; tick();
        // R8: ack held, counting restarts, frame pulse releases
        cur_req = "R8";
        echo(1'b1, 3); tick();
        frame_pulse = 1'b1; tick(); frame_pulse = 1'b0; tick(); tick();
        // R7: sticky until cleared
        cur_req = "R7";
        tick(); tick();
        irq_clear = 1'b1; tick(); irq_clear = 1'b0; tick();

        // R11: collision and done together; frame pulse during abort
        cur_req = "R11";
        tx_pending = 1'b1;
        echo(1'b1, 10); tick();
        tx_pending = 1'b0;
        echo_vld = 1'b1; echo_bit = 1'b1; tx_dbit = 1'b0; pkt_done = 1'b1; tick();
        echo_vld = 1'b0; pkt_done = 1'b0;
        frame_pulse = 1'b1; tick(); frame_pulse = 1'b0; tick();
        // R7: set wins over simultaneous clear
        cur_req = "R7";
        irq_clear = 1'b1; tick(); irq_clear = 1'b0;
        tx_pending = 1'b1;
        echo(1'b1, 10); tick();
        tx_pending = 1'b0;
        echo_vld = 1'b1; echo_bit = 1'b0; tx_dbit = 1'b1; irq_clear = 1'b1; tick();
        echo_vld = 1'b0; irq_clear = 1'b0; tick(); tick();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule